// File: doc/BRIEF.md
# Aligned transfer length segmenter

This block accepts one buffer request, a 32-bit start address and a byte count, and breaks it into a series of segments. Each segment is no longer than the largest count that one transfer channel can take. A long request is not cut into full-size pieces followed by a short tail. Instead, the block divides the remaining length into a small number of nearly equal pieces whose lengths are multiples of four. Only the final piece can carry odd low bits.

Requests arrive on a valid/ready input. Segments leave on a valid/ready output that carries the segment address, the segment length and a last marker. A request whose start address is not word aligned, or whose length is zero, is refused: an error strobe is raised for one cycle and no segment is produced. Each piece length needs two divisions. They are done by a shared bit-serial divider, so the input is held not-ready while a request is being split.

Top module: `seg_splitter`

## Requirements
- R1: Every emitted segment has a length between 1 and 0x1FFF inclusive.
- R2: A request whose address has bit 0 or bit 1 set is accepted and then refused. `err_o` is high for exactly one cycle, in the cycle after the accepting edge. No segment is emitted for it.
- R3: A request with zero length is refused in the same way as in R2.
- R4: When the remaining length is 0x1FFF or less, it is emitted as one segment of exactly that length.
- R5: When the remaining length r exceeds 0x1FFF, the segment length is floor(r / ceil(r / 0x1FFC)) with bits [1:0] forced to zero.
- R6: The first segment starts at the request address. Each later segment starts where the previous one ended, and the next split is computed from the reduced remainder.
- R7: `req_ready_o` is low from the accepting edge until the handshake of the final segment, or until the error cycle ends. It is high again in the cycle after that handshake.
- R8: While `seg_valid_o` is high and `seg_ready_i` is low, the segment address, length and last flag stay unchanged.
- R9: `seg_last_o` is high on exactly the segment whose length equals the remaining length. After that segment is handed over, `seg_valid_o` drops.
- R10: An active reset abandons any partly split request. During reset and afterwards the outputs are idle: no segment valid, no error, input ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can take a request |
| req_addr_i | input | 32 | Buffer start address |
| req_len_i | input | 24 | Buffer length in bytes |
| seg_valid_o | output | 1 | Segment present |
| seg_ready_i | input | 1 | Consumer takes segment |
| seg_addr_o | output | 32 | Segment start address |
| seg_len_o | output | 13 | Segment length in bytes |
| seg_last_o | output | 1 | Final segment of the request |
| err_o | output | 1 | One-cycle strobe for a refused request |

## Verification
Two events can coincide: the final segment is handed over, and a new request is presented in that same cycle. The bench raises the next request valid in the same cycle in which it accepts the last segment. It then checks two things. The new request must not be taken on that edge, because the input is still not ready. The request must then be accepted one cycle later, and its own segments must follow with the correct addresses. Consumer stalls in the middle of a long split are also applied, and the segment fields are compared against the values captured when the stall began.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RJCT,
    ST_CALC,
    ST_DIV1,
    ST_DIV2,
    ST_EMIT
  } seg_state_e;
endpackage

// File: rtl/seg_req_check.sv
module seg_req_check #(
  parameter int LEN_W      = 24,
  parameter int ALIGN_BITS = 2
) (
  input  logic [ALIGN_BITS-1:0] addr_lo_i,
  input  logic [LEN_W-1:0]      len_i,
  output logic                  bad_o
);
  logic misaligned, zero_len;
  assign misaligned = |addr_lo_i;
  assign zero_len   = (len_i == '0);
  assign bad_o      = misaligned | zero_len;
endmodule

// File: rtl/seg_div.sv
module seg_div #(
  parameter int W = 25
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, den_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    rem_sh, diff;
  logic          ge;

  assign rem_sh = {rem_q, quo_q[W-1]};
  assign diff   = rem_sh - {1'b0, den_q};
  assign ge     = ~diff[W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (start_i) begin
      rem_q  <= '0;
      quo_q  <= dividend_i;
      den_q  <= divisor_i;
      cnt_q  <= CW'(W);
      done_o <= 1'b0;
    end else if (cnt_q != '0) begin
      rem_q  <= ge ? diff[W-1:0] : rem_sh[W-1:0];
      quo_q  <= {quo_q[W-2:0], ge};
      cnt_q  <= cnt_q - 1'b1;
      done_o <= (cnt_q == CW'(1));
    end else begin
      done_o <= 1'b0;
    end
  end

  assign quot_o = quo_q;

  AST_DIV_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> divisor_i != '0); // R5
  AST_DIV_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
endmodule

// File: rtl/seg_splitter.sv
module seg_splitter
  import seg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 24,
  parameter int SEG_W      = 13,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              seg_valid_o,
  input  logic              seg_ready_i,
  output logic [ADDR_W-1:0] seg_addr_o,
  output logic [SEG_W-1:0]  seg_len_o,
  output logic              seg_last_o,
  output logic              err_o
);
  localparam int SEG_MAX = (1 << SEG_W) - 1;
  localparam int A_MASK  = (1 << ALIGN_BITS) - 1;
  localparam int STEP    = SEG_MAX & ~A_MASK;
  localparam int DW      = LEN_W + 1;

  seg_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [SEG_W-1:0]  len_q;

  logic              req_bad;
  logic              div_start, div_done;
  logic [DW-1:0]     div_dividend, div_divisor, div_quot;
  logic              fits;

  seg_req_check #(.LEN_W(LEN_W), .ALIGN_BITS(ALIGN_BITS)) u_check (
    .addr_lo_i (req_addr_i[ALIGN_BITS-1:0]),
    .len_i     (req_len_i),
    .bad_o     (req_bad)
  );

  seg_div #(.W(DW)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .dividend_i (div_dividend),
    .divisor_i  (div_divisor),
    .done_o     (div_done),
    .quot_o     (div_quot)
  );

  assign fits = (rem_q <= LEN_W'(SEG_MAX));

  // First pass: ceiling piece count; second pass: piece length.
  always_comb begin
    div_start    = 1'b0;
    div_dividend = {1'b0, rem_q} + DW'(STEP - 1);
    div_divisor  = DW'(STEP);
    if (state_q == ST_CALC && !fits) begin
      div_start = 1'b1;
    end else if (state_q == ST_DIV1 && div_done) begin
      div_start    = 1'b1;
      div_dividend = {1'b0, rem_q};
      div_divisor  = div_quot;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      len_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          if (req_bad) begin
            state_q <= ST_RJCT;
          end else begin
            addr_q  <= req_addr_i;
            rem_q   <= req_len_i;
            state_q <= ST_CALC;
          end
        end
        ST_RJCT: state_q <= ST_IDLE;
        ST_CALC: if (fits) begin
          len_q   <= SEG_W'(rem_q);
          state_q <= ST_EMIT;
        end else begin
          state_q <= ST_DIV1;
        end
        ST_DIV1: if (div_done) state_q <= ST_DIV2;
        ST_DIV2: if (div_done) begin
          len_q   <= SEG_W'(div_quot & ~DW'(A_MASK));
          state_q <= ST_EMIT;
        end
        ST_EMIT: if (seg_ready_i) begin
          addr_q  <= addr_q + ADDR_W'(len_q);
          rem_q   <= rem_q - LEN_W'(len_q);
          state_q <= seg_last_o ? ST_IDLE : ST_CALC;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign seg_valid_o = (state_q == ST_EMIT);
  assign seg_addr_o  = addr_q;
  assign seg_len_o   = len_q;
  assign seg_last_o  = (rem_q == LEN_W'(len_q));
  assign err_o       = (state_q == ST_RJCT);

  AST_SEG_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o |-> (seg_len_o != '0) && (int'(seg_len_o) <= SEG_MAX)); // R1
  AST_SEG_LEN_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_valid_o && !seg_last_o) |-> (seg_len_o[ALIGN_BITS-1:0] == '0)); // R5
  AST_ERR_NO_SEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !seg_valid_o && !req_ready_o); // R2
  AST_BUSY_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o |-> !req_ready_o); // R7
  AST_SEG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_valid_o && !seg_ready_i) |=> seg_valid_o && $stable(seg_addr_o)
      && $stable(seg_len_o) && $stable(seg_last_o)); // R8
  AST_LAST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_valid_o && seg_ready_i && seg_last_o) |=> !seg_valid_o && req_ready_o); // R9
endmodule

// File: tb/seg_splitter_tb.sv
module seg_splitter_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [23:0] req_len = '0;
  logic        seg_valid;
  logic        seg_ready = 1'b0;
  logic [31:0] seg_addr;
  logic [12:0] seg_len;
  logic        seg_last;
  logic        err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  seg_splitter u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_len_i(req_len),
    .seg_valid_o(seg_valid), .seg_ready_i(seg_ready),
    .seg_addr_o(seg_addr), .seg_len_o(seg_len), .seg_last_o(seg_last),
    .err_o(err)
  );

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_len(input int r);
    int m;
    if (r <= 'h1FFF) return r;
    m = (r + 'h1FFB) / 'h1FFC;
    return (r / m) & ~3;
  endfunction

  task automatic send_req(input logic [31:0] a, input logic [23:0] l);
    req_addr = a;
    req_len = l;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Collect all segments of one request; optionally present the next request
  // in the same cycle as the final handshake.
  task automatic collect(input logic [31:0] a, input int l, input int stall,
                         input bit chain, input logic [31:0] na, input logic [23:0] nl);
    logic [31:0] ea = a;
    int rem = l;
    bit busy_ok = 1'b1;
    bit stable_ok = 1'b1;
    bit shape_ok = 1'b1;
    while (rem != 0) begin
      int el = exp_len(rem);
      int w = 0;
      logic [31:0] sa;
      logic [12:0] sl;
      logic sla;
      while (!seg_valid) begin
        if (req_ready) busy_ok = 1'b0;
        @(negedge clk);
        w++;
        if (w > 2000) begin
          chk(1'b0, "R6 segment timeout", 0, 1);
          return;
        end
      end
      sa = seg_addr; sl = seg_len; sla = seg_last;
      for (int s = 0; s < stall; s++) begin
        seg_ready = 1'b0;
        @(negedge clk);
        if (!seg_valid || seg_addr != sa || seg_len != sl || seg_last != sla) stable_ok = 1'b0;
      end
      if (seg_addr != ea) begin
        shape_ok = 1'b0;
        chk(1'b0, "R6 address", seg_addr, ea);
      end
      if (int'(seg_len) != el) begin
        shape_ok = 1'b0;
        chk(1'b0, (rem > 'h1FFF) ? "R5 split length" : "R4 whole length", seg_len, el);
      end
      if (seg_last != (el == rem)) begin
        shape_ok = 1'b0;
        chk(1'b0, "R9 last flag", seg_last, el == rem);
      end
      if (seg_len == 0 || seg_len > 13'h1FFF) shape_ok = 1'b0;
      if (el == rem && chain) begin
        req_addr = na; req_len = nl; req_valid = 1'b1;
      end
      seg_ready = 1'b1;
      @(negedge clk);
      seg_ready = 1'b0;
      ea += el;
      rem -= el;
    end
    chk(shape_ok, "R1 R5 R6 segment series", shape_ok, 1);
    chk(busy_ok, "R7 ready low while splitting", busy_ok, 1);
    chk(stable_ok, "R8 hold under stall", stable_ok, 1);
    chk(!seg_valid, "R9 valid drops after last", seg_valid, 0);
    chk(req_ready, "R7 ready after last", req_ready, 1);
    if (chain) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk(!seg_valid && !err && req_ready, "R10 reset state", {seg_valid, err, req_ready}, 3'b001);
  endtask

  task automatic t_single();
    send_req(32'h0000_1000, 24'h1FFF); // R4 boundary
    collect(32'h0000_1000, 'h1FFF, 0, 1'b0, '0, '0);
    send_req(32'h0000_2000, 24'd1);
    collect(32'h0000_2000, 1, 0, 1'b0, '0, '0);
  endtask

  task automatic t_split();
    send_req(32'h0001_0000, 24'h2000); // R5 just over the limit
    collect(32'h0001_0000, 'h2000, 0, 1'b0, '0, '0);
    send_req(32'h0002_0004, 24'h4000);
    collect(32'h0002_0004, 'h4000, 0, 1'b0, '0, '0);
    send_req(32'h0004_0000, 24'h3_0001); // R6 many pieces, odd tail
    collect(32'h0004_0000, 'h3_0001, 0, 1'b0, '0, '0);
  endtask

  task automatic t_stall();
    send_req(32'h8000_0000, 24'h6003); // R8
    collect(32'h8000_0000, 'h6003, 3, 1'b0, '0, '0);
  endtask

  task automatic t_reject(input logic [31:0] a, input logic [23:0] l, input string tag);
    bit seen = 1'b0;
    send_req(a, l);
    chk(err && !seg_valid, tag, {err, seg_valid}, 2'b10);
    @(negedge clk);
    chk(!err && req_ready, tag, {err, req_ready}, 2'b01);
    for (int i = 0; i < 40; i++) begin
      if (seg_valid) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, tag, seen, 0);
  endtask

  task automatic t_chain();
    send_req(32'h0010_0000, 24'h2400);
    collect(32'h0010_0000, 'h2400, 1, 1'b1, 32'h0020_0000, 24'h0123);
    chk(!req_ready, "R7 chained request taken", req_ready, 0);
    collect(32'h0020_0000, 'h0123, 0, 1'b0, '0, '0);
  endtask

  task automatic t_midreset();
    send_req(32'h0030_0000, 24'h9000);
    repeat (30) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(!seg_valid && req_ready && !err, "R10 reset mid split", {seg_valid, req_ready, err}, 3'b010);
    rst_ni = 1'b1;
    repeat (60) @(negedge clk);
    chk(!seg_valid && req_ready, "R10 request dropped", {seg_valid, req_ready}, 2'b01);
    send_req(32'h0040_0000, 24'h2004);
    collect(32'h0040_0000, 'h2004, 0, 1'b0, '0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_split();
    t_stall();
    t_reject(32'h0000_1001, 24'h0100, "R2 bit0 misaligned");
    t_reject(32'h0000_1002, 24'h0100, "R2 bit1 misaligned");
    t_reject(32'h0000_1000, 24'h0000, "R3 zero length");
    t_chain();
    t_midreset();
    finish_run();
  end
endmodule